// File: doc/BRIEF.md
# Clock-Synchronous Serial Master Transceiver

This block is an 8-bit, full-duplex serial shifter that owns the transfer clock. It generates the shift clock from the system clock through a programmable divider. It drives the serial output line and samples the serial input line. A single write from the host starts a transfer. Eight bits then leave on the output line while eight bits arrive on the input line.

Three static controls shape the transfer:

- **Polarity.** One bit sets the level at which the shift clock rests. It also fixes which clock edge launches data and which edge captures it. With polarity 0 the clock rests high, data is launched on falling edges and captured on rising edges. With polarity 1 the clock rests low, data is launched on rising edges and captured on falling edges.
- **Bit order.** One bit chooses whether the least or the most significant bit goes first.
- **Inversion.** One bit complements the data on the line in both directions.

The controls and the divider setting are tracked while the block is idle. They are frozen for the length of a transfer. The host sees a busy flag, a one-cycle completion strobe and the received byte, which stays on its port until the next transfer ends.

Top module: `sync_shift_master`

## Requirements
- R1: After reset, `busy` and `rx_done` are 0, `rx_data` is 0 and `sclk` is 1.
- R2: While idle, `sclk` rests at the inverse of `cfg_pol` (1 for polarity 0, 0 for polarity 1), following a change of `cfg_pol` within two clock cycles.
- R3: During a transfer, each bit is launched on the edge that leaves the rest level and captured on the edge that returns to it. The value on `sdo` at every capturing edge is the bit scheduled for that position.
- R4: With `cfg_msb` = 0, bit 0 travels first and bit 7 last; with `cfg_msb` = 1, bit 7 travels first and bit 0 last. Both directions use the same order.
- R5: With `cfg_inv` = 1, `sdo` carries the complement of each written bit, and `rx_data` is the complement of the bits sampled from `sdi`. With `cfg_inv` = 0, data passes unchanged.
- R6: A transfer has exactly eight capturing edges. `busy` stays high for exactly 16×(`div_n`+1) system cycles, starting the cycle after the accepted write.
- R7: `rx_done` is high for exactly one cycle when the last bit is captured. `rx_data` changes only together with `rx_done`.
- R8: A write while `busy` is high is ignored; the running transfer sends its original byte.
- R9: Changes of `cfg_pol`, `cfg_msb`, `cfg_inv` or `div_n` during a transfer have no effect on it.
- R10: Every shift clock edge, and the first edge after the start, is spaced exactly `div_n`+1 system cycles from the previous event.
- R11: The first data bit appears on `sdo` at the first launching edge, half a shift clock period before its capture edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_n | input | DIV_W | Divider setting N; shift clock period is 2×(N+1) system cycles |
| cfg_pol | input | 1 | Clock polarity and edge selection |
| cfg_msb | input | 1 | 1: most significant bit first |
| cfg_inv | input | 1 | 1: invert data in both directions |
| wr_en | input | 1 | Write strobe; starts a transfer when idle |
| wr_data | input | DATA_W | Byte to transmit |
| busy | output | 1 | Transfer in progress |
| rx_done | output | 1 | One-cycle completion strobe |
| rx_data | output | DATA_W | Last received byte |
| sclk | output | 1 | Shift clock to the peer |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A wrong edge counter shows up as a missing or extra capturing edge, and as a `busy` window of the wrong length. Both are visible at the end of the very transfer in which the counter went wrong. A divider count that drifts shows up on the next shift clock edge as a wrong spacing. A wrong order or inversion state appears on `sdo` at the first capturing edge, and in `rx_data` at the `rx_done` strobe. A configuration register that is not frozen during a transfer corrupts the bits launched after the disturbing write. That corruption is visible at the following capturing edge.

// File: rtl/ssm_pkg.sv
// Shared types for the clock-synchronous serial master.
// Assumes: all three mode bits are sampled together as one word.
package ssm_pkg;
    // Mode word: clock polarity, bit order, data inversion.
    typedef struct packed {
        logic pol;
        logic msb;
        logic inv;
    } ssm_cfg_t;
endpackage

// File: rtl/ssm_clk_div.sv
// Half-period tick generator for the shift clock.
// Produces one tick every (div_q+1) cycles while run is high.
// Assumes: div_q is loaded on the start strobe, when run is still low,
// so the count always begins at zero.
module ssm_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt;

    // Capture the divider setting only when a transfer begins.
    always_ff @(posedge clk) begin
        if (!rst_n)     div_q <= '0;
        else if (start) div_q <= div_n;
    end

    // Count system cycles within one half period.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (!run || cnt == div_q) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == div_q);

    // R10: the counter never passes the frozen limit.
    assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= div_q);
    // R9: the divider setting is frozen while running.
    assert_div_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) |-> $stable(div_q));
endmodule

// File: rtl/ssm_shifter.sv
// Shift engine: generates the shift clock from ticks, launches and captures bits.
// Edge k of 2*DATA_W: odd k leaves the rest level and launches, even k returns
// to it and captures. Bit order and inversion are resolved at load and unload,
// so the shift registers always move least significant bit first.
// Assumes: tick is low whenever busy is low.
module ssm_shifter
    import ssm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  ssm_cfg_t          cfg_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sdi,
    output logic              start,
    output logic              busy,
    output logic              sclk,
    output logic              sdo,
    output logic              rx_done,
    output logic [DATA_W-1:0] rx_data
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES + 1);

    ssm_cfg_t          cfg_q;
    logic [DATA_W-1:0] tx_sr, rx_sr, tx_prep, rx_next, rx_fix;
    logic [EW-1:0]     edg;
    logic              leading, last;

    assign start   = wr_en && !busy;
    assign leading = ~edg[0];
    assign last    = tick && (edg == EW'(EDGES - 1));
    assign rx_next = {sdi, rx_sr[DATA_W-1:1]};

    // Reorder and invert the outgoing word, and restore the incoming one.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            tx_prep[i] = (cfg_in.msb ? wr_data[DATA_W-1-i] : wr_data[i]) ^ cfg_in.inv;
            rx_fix[i]  = (cfg_q.msb ? rx_next[DATA_W-1-i] : rx_next[i]) ^ cfg_q.inv;
        end
    end

    // Track the mode inputs while idle and hold them during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (!busy) cfg_q <= cfg_in;
    end

    // Sequence the transfer: clock edges, bit launch, bit capture, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sclk    <= 1'b1;
            sdo     <= 1'b1;
            edg     <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            rx_done <= 1'b0;
            rx_data <= '0;
        end else begin
            rx_done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                edg   <= '0;
                tx_sr <= tx_prep;
                sclk  <= ~cfg_in.pol;
            end else if (busy && tick) begin
                sclk <= ~sclk;
                edg  <= edg + 1'b1;
                if (leading) begin
                    sdo   <= tx_sr[0];
                    tx_sr <= tx_sr >> 1;
                end else begin
                    rx_sr <= rx_next;
                end
                if (last) begin
                    busy    <= 1'b0;
                    rx_done <= 1'b1;
                    rx_data <= rx_fix;
                end
            end else if (!busy) begin
                sclk <= ~cfg_in.pol;
            end
        end
    end

    // R2: at rest the clock sits at the level the held polarity selects.
    assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk == ~cfg_q.pol);
    // R7: the completion strobe lasts one cycle.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);
    // R7: received byte only moves with the strobe.
    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |-> $stable(rx_data));
    // R9: the mode word is frozen during a transfer.
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(cfg_q));
    // R6: the edge counter stays within one transfer.
    assert_edge_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        edg <= EW'(EDGES));
    // R6: a transfer ends only together with the completion strobe.
    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rx_done);
endmodule

// File: rtl/sync_shift_master.sv
// Top of the clock-synchronous serial master transceiver.
// Joins the half-period tick generator and the shift engine.
// Assumes: sdi is already synchronous to clk, or settled around capture edges.
module sync_shift_master
    import ssm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              cfg_pol,
    input  logic              cfg_msb,
    input  logic              cfg_inv,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              rx_done,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              sdo,
    input  logic              sdi
);
    ssm_cfg_t cfg_in;
    logic     tick;
    logic     start;

    assign cfg_in = '{pol: cfg_pol, msb: cfg_msb, inv: cfg_inv};

    ssm_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .run   (busy),
        .div_n (div_n),
        .tick  (tick)
    );

    ssm_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cfg_in  (cfg_in),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sdi     (sdi),
        .start   (start),
        .busy    (busy),
        .sclk    (sclk),
        .sdo     (sdo),
        .rx_done (rx_done),
        .rx_data (rx_data)
    );
endmodule

// File: tb/sim_sync_shift_master.sv
// Scoreboard bench: the driver task queues the expected line bits and bytes.
// A monitor on the falling clock edge plays the peer and compares results.
module sim_sync_shift_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_n = '0;
    logic       pol = 1'b0, msb = 1'b0, inv = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       sdi = 1'b0;
    logic       busy, rx_done, sclk, sdo;
    logic [7:0] rx_data;

    always #2 clk = ~clk;   // 250 MHz

    sync_shift_master u0 (
        .clk(clk), .rst_n(rst_n), .div_n(div_n), .cfg_pol(pol), .cfg_msb(msb),
        .cfg_inv(inv), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
        .rx_done(rx_done), .rx_data(rx_data), .sclk(sclk), .sdo(sdo), .sdi(sdi)
    );

    int         errors = 0, checks = 0;
    longint     cyc = 0, last_edge = 0, busy_cnt = 0;
    logic       exp_bits[$];
    logic       sl_bits[$];
    logic [7:0] exp_rx[$];
    logic       cur_pol = 1'b0;
    int         cur_div = 0;
    int         trail_cnt = 0;
    bit         in_xfer = 0, finished = 0;
    logic       prev_sclk = 1'b1, prev_busy = 1'b0, prev_done = 1'b0;
    logic [7:0] last_slave = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // Driver: queue expectations, then start a transfer; optionally disturb it.
    task automatic xfer(input logic [7:0] d, input logic [7:0] s, input logic p,
                        input logic m, input logic v, input logic [7:0] dv, input bit disturb);
        pol = p; msb = m; inv = v; div_n = dv;
        step(3);
        chk(sclk == !p, "R2 rest level before start", sclk, !p);
        for (int j = 0; j < 8; j++) begin
            int idx = m ? 7 - j : j;
            exp_bits.push_back(v ^ d[idx]);
            sl_bits.push_back(v ^ s[idx]);
        end
        exp_rx.push_back(s);
        last_slave = s;
        cur_pol = p; cur_div = int'(dv); trail_cnt = 0; in_xfer = 1;
        wr_en = 1'b1; wr_data = d;
        step(1);
        wr_en = 1'b0;
        if (disturb) begin
            step(5);
            // R8 and R9: a second write and new modes while busy must not matter.
            wr_en = 1'b1; wr_data = ~d; pol = ~p; msb = ~m; inv = ~v; div_n = dv + 8'd2;
            step(1);
            wr_en = 1'b0;
        end
        wait (!in_xfer);
        step(2);
    endtask

    // Monitor and peer model, sampled away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_done) chk(!rx_done, "R7 strobe width", rx_done, 0);
            if (in_xfer) begin
                if (busy && !prev_busy) begin last_edge = cyc; busy_cnt = 0; end
                if (busy) busy_cnt++;
                if (sclk != prev_sclk) begin
                    chk(cyc - last_edge == longint'(cur_div + 1), "R10 edge spacing",
                        32'(cyc - last_edge), 32'(cur_div + 1));
                    last_edge = cyc;
                    if (sclk == cur_pol) begin
                        // leading edge: peer presents its next bit
                        if (sl_bits.size() > 0) sdi = sl_bits.pop_front();
                        if (exp_bits.size() > 0)
                            chk(sdo == exp_bits[0], "R11 bit on line at launch", sdo, exp_bits[0]);
                    end else begin
                        trail_cnt++;
                        if (exp_bits.size() > 0) begin
                            logic e;
                            e = exp_bits.pop_front();
                            chk(sdo == e, "R3/R4/R5/R8/R9 bit at capture", sdo, e);
                        end
                    end
                end
                if (!busy && prev_busy)
                    chk(busy_cnt == 16 * (cur_div + 1), "R6 busy length",
                        32'(busy_cnt), 32'(16 * (cur_div + 1)));
                if (rx_done) begin
                    logic [7:0] e;
                    e = exp_rx.pop_front();
                    chk(rx_data == e, "R4/R5/R9 received byte", rx_data, e);
                    chk(trail_cnt == 8, "R6 capture count", trail_cnt, 8);
                    in_xfer = 0;
                end
            end
        end
        prev_sclk = sclk;
        prev_busy = busy;
        prev_done = rx_done;
    end

    initial begin
        step(3);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(rx_done == 1'b0, "R1 strobe after reset", rx_done, 0);
        chk(rx_data == 8'h00, "R1 byte after reset", rx_data, 0);
        chk(sclk == 1'b1, "R1 clock after reset", sclk, 1);
        rst_n = 1'b1;
        step(2);
        pol = 1'b1; step(2);
        chk(sclk == 1'b0, "R2 rest low for polarity 1", sclk, 0);
        pol = 1'b0; step(2);
        chk(sclk == 1'b1, "R2 rest high for polarity 0", sclk, 1);

        xfer(8'hA5, 8'h3C, 0, 0, 0, 8'd0, 0);
        xfer(8'h81, 8'h7E, 1, 0, 0, 8'd1, 0);
        xfer(8'hC3, 8'h5A, 0, 1, 0, 8'd0, 0);
        xfer(8'h1E, 8'hE1, 1, 1, 0, 8'd2, 0);
        xfer(8'hF0, 8'h96, 0, 0, 1, 8'd1, 0);
        xfer(8'h6D, 8'hB2, 1, 1, 1, 8'd3, 0);
        xfer(8'h00, 8'hFF, 0, 1, 1, 8'd0, 1);
        xfer(8'h4B, 8'h27, 1, 0, 1, 8'd2, 1);

        step(20);
        chk(rx_data == last_slave, "R7 byte held after completion", rx_data, last_slave);
        chk(rx_done == 1'b0, "R7 no strobe while idle", rx_done, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule